// File: doc/BRIEF.md
# Register-Mapped Random Word Generator

This block is a small random-word peripheral on a plain 32-bit register port. Software writes a control word to choose which entropy sources are enabled and to set a clock-divider exponent. It then waits for the ready flag in the status register and reads 32-bit words from the data register. The entropy source here is a behavioural stand-in: a 32-bit Galois shift register that is stepped on a divided clock. Two fault inputs let a testbench or a monitor raise seed errors and clock errors.

Source configuration can only be changed inside a conditional-reset window. A control write that sets the conditional-reset bit captures the configuration fields. A later write that clears the bit starts a fixed internal restart, and the bit keeps reading as 1 until that restart is over. A seed error stops generation and forces data reads to zero. When the fault goes away the block recovers by itself, but it has to produce a fresh run of words before it reports ready again. A lock bit freezes the configuration until the next hardware reset.

Top module: `rng_periph`

## Requirements
- R1: After reset, control, status, noise-control and health-test registers read 0 and a data read returns 0.
- R2: Control bits 29:4 (bit 5 clock-detect-off; source fields at 11:8, 15:13, 25:20; bit 12; divider exponent at 19:16) change only on a control write (offset 0x00) that also has bit 30 set. Bit 2 (enable) follows every unlocked or locked control write.
- R3: Writing bit 30 as 1 makes it read 1. A later write with bit 30 at 0 keeps it reading 1 for 16 more clock edges. It reads 0 from the 16th edge on.
- R4: After a restart, status bit 0 (ready) rises only when 12 words have been produced. One word is produced every 4 ticks of a clock divided by 2 to the power of the exponent.
- R5: When ready, a data read (offset 0x08) returns a nonzero word and consumes it. Later reads return different words.
- R6: With all three source fields at 0, the block never becomes ready and data reads return 0.
- R7: While enabled, an asserted seed fault sets status bits 2 (seed now) and 6 (seed event) at the next edge, clears ready, and makes data reads return 0.
- R8: When the seed fault clears, bit 2 clears by itself and bit 6 stays set. Ready returns only after 12 new words. Writing 0 to status bit 6 clears it; writing 1 leaves it unchanged.
- R9: With control bit 5 at 0, a clock fault sets status bits 1 (clock now) and 5 (clock event). Bit 1 follows the fault, and bit 5 holds until a status write puts 0 there. With bit 5 at 1, clock faults have no effect.
- R10: Once control bit 31 (lock) is set, the config fields, bit 30, bit 31 and the noise and health registers ignore writes until reset. Enable stays writable.
- R11: The noise-control register (0x0C) keeps only its low 18 bits, and bits 31:18 read 0. The health-test register (0x10) keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes a data word) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| seed_fault_in | input | 1 | Injected seed/noise fault |
| clk_fault_in | input | 1 | Injected clock-too-slow indication |

## Verification
The checks assume that configuration changes only arrive through conditional-reset writes. They also assume that read strobes and addresses are stable for a whole cycle, and that faults are level inputs that hold for at least one edge. The bench drives every input at the falling edge, holds each strobe for exactly one cycle, and changes configuration only through a set-then-clear pair of control writes. It samples timing-critical flags at a fixed number of edges after the restart write. For each ready check it uses one sample before the computed rising edge and one after it.

// File: rtl/rng_pkg.sv
// Package: register word offsets, control/status bit positions and the
// captured configuration type shared by the random word generator.
package rng_pkg;
    localparam int REG_W      = 32;
    localparam int OFS_CTRL   = 0;
    localparam int OFS_STAT   = 4;
    localparam int OFS_DATA   = 8;
    localparam int OFS_NSRC   = 12;
    localparam int OFS_HTST   = 16;

    localparam int CB_EN      = 2;
    localparam int CB_CEDOFF  = 5;
    localparam int CB_CRST    = 30;
    localparam int CB_LOCK    = 31;

    localparam int SB_READY   = 0;
    localparam int SB_CLKNOW  = 1;
    localparam int SB_SEEDNOW = 2;
    localparam int SB_CLKEVT  = 5;
    localparam int SB_SEEDEVT = 6;

    typedef struct packed {
        logic [5:0] src_c;
        logic [3:0] div_exp;
        logic [2:0] src_b;
        logic       nist;
        logic [3:0] src_a;
        logic       ced_off;
    } rng_cfg_t;
endpackage

// File: rtl/rng_ctrl.sv
// Control, noise-control and health-test registers.
// Captures configuration only on writes with the restart bit set, runs the
// post-restart countdown and holds the lock. Assumes one-cycle write strobes.
module rng_ctrl
    import rng_pkg::*;
#(
    parameter int               COND_CYCLES = 16,
    parameter int               NSRC_W      = 18,
    parameter logic [NSRC_W-1:0] NSRC_RST   = '0,
    parameter logic [REG_W-1:0] HTST_RST    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              nsrc_wr,
    input  logic              htst_wr,
    input  logic [REG_W-1:0]  wdata,
    output logic              enable,
    output rng_cfg_t          cfg,
    output logic              cond_active,
    output logic              cfg_locked,
    output logic [REG_W-1:0]  ctrl_rdata,
    output logic [NSRC_W-1:0] nsrc_q,
    output logic [REG_W-1:0]  htst_q
);
    localparam int CNT_W = $clog2(COND_CYCLES + 1);

    logic             en_q;
    logic             crst_q;
    logic             lock_q;
    logic [CNT_W-1:0] busy_cnt;
    rng_cfg_t         cfg_q;
    rng_cfg_t         cfg_new;

    // Decode configuration fields from the write data.
    always_comb begin
        cfg_new.src_c   = wdata[25:20];
        cfg_new.div_exp = wdata[19:16];
        cfg_new.src_b   = wdata[15:13];
        cfg_new.nist    = wdata[12];
        cfg_new.src_a   = wdata[11:8];
        cfg_new.ced_off = wdata[CB_CEDOFF];
    end

    // Control register state: enable, restart window, countdown, lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            crst_q   <= 1'b0;
            lock_q   <= 1'b0;
            busy_cnt <= '0;
            cfg_q    <= '0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (ctrl_wr) begin
                en_q <= wdata[CB_EN];
                if (!lock_q) begin
                    if (wdata[CB_LOCK]) lock_q <= 1'b1;
                    if (wdata[CB_CRST]) begin
                        crst_q <= 1'b1;
                        cfg_q  <= cfg_new;
                    end else if (crst_q) begin
                        crst_q   <= 1'b0;
                        busy_cnt <= CNT_W'(COND_CYCLES);
                    end
                end
            end
        end
    end

    // Noise-control and health-test registers, frozen by the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsrc_q <= NSRC_RST;
            htst_q <= HTST_RST;
        end else if (!lock_q) begin
            if (nsrc_wr) nsrc_q <= wdata[NSRC_W-1:0];
            if (htst_wr) htst_q <= wdata;
        end
    end

    assign enable      = en_q;
    assign cfg         = cfg_q;
    assign cfg_locked  = lock_q;
    assign cond_active = crst_q | (busy_cnt != '0);
    assign ctrl_rdata  = {lock_q, cond_active, 4'b0, cfg_q.src_c, cfg_q.div_exp,
                          cfg_q.src_b, cfg_q.nist, cfg_q.src_a, 2'b0,
                          cfg_q.ced_off, 2'b0, en_q, 2'b0};
endmodule

// File: rtl/rng_source.sv
// Behavioural entropy stand-in: a divided tick clock and a Galois shift
// register advanced by one full word every TICKS_PER_WORD ticks.
// Assumes run drops whenever generation must stop; counters restart then.
module rng_source
    import rng_pkg::*;
#(
    parameter int               DIV_W          = 4,
    parameter int               TICKS_PER_WORD = 4,
    parameter logic [REG_W-1:0] SEED           = 32'h1D2C_3B4A,
    parameter logic [REG_W-1:0] POLY           = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_exp,
    output logic             word_stb,
    output logic [REG_W-1:0] word
);
    localparam int TICK_W = 1 << DIV_W;
    localparam int SUB_W  = (TICKS_PER_WORD > 1) ? $clog2(TICKS_PER_WORD) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_WORD - 1);

    logic [TICK_W-1:0] tick_cnt;
    logic [TICK_W-1:0] tick_lim;
    logic [SUB_W-1:0]  sub_cnt;
    logic [REG_W-1:0]  lfsr_q;
    logic              stb_q;
    logic              tick;

    // Step the shift register once per output bit.
    function automatic logic [REG_W-1:0] next_word(input logic [REG_W-1:0] s);
        logic [REG_W-1:0] v;
        v = s;
        for (int i = 0; i < REG_W; i++) begin
            v = v[0] ? ((v >> 1) ^ POLY) : (v >> 1);
        end
        return v;
    endfunction

    assign tick_lim = (TICK_W'(1) << div_exp) - TICK_W'(1);
    assign tick     = (tick_cnt == tick_lim);

    // Divided tick, tick-per-word counter and word production.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            sub_cnt  <= '0;
            stb_q    <= 1'b0;
            lfsr_q   <= SEED;
        end else if (!run) begin
            tick_cnt <= '0;
            sub_cnt  <= '0;
            stb_q    <= 1'b0;
        end else begin
            stb_q <= tick && (sub_cnt == SUB_LAST);
            if (tick) begin
                tick_cnt <= '0;
                sub_cnt  <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
                if (sub_cnt == SUB_LAST) lfsr_q <= next_word(lfsr_q);
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    assign word_stb = stb_q;
    assign word     = lfsr_q;
endmodule

// File: rtl/rng_outbuf.sv
// Output stage: counts words since the last flush and presents one word
// once the pipeline has seen PIPE_WORDS words. Assumes pop only when valid.
module rng_outbuf
    import rng_pkg::*;
#(
    parameter int PIPE_WORDS = 12,
    parameter int FILL_W     = $clog2(PIPE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              word_stb,
    input  logic [REG_W-1:0]  word,
    input  logic              pop,
    output logic              dr_valid,
    output logic [REG_W-1:0]  dr_word,
    output logic [FILL_W-1:0] fill
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(PIPE_WORDS);
    localparam logic [FILL_W-1:0] NEAR = FILL_W'(PIPE_WORDS - 1);

    logic [FILL_W-1:0] fill_q;
    logic              valid_q;
    logic [REG_W-1:0]  word_q;

    // Fill count and presented word; flush restarts the warm-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q  <= '0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (flush) begin
            fill_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (pop) valid_q <= 1'b0;
            if (word_stb) begin
                if (fill_q != FULL) fill_q <= fill_q + 1'b1;
                if ((fill_q >= NEAR) && (!valid_q || pop)) begin
                    valid_q <= 1'b1;
                    word_q  <= word;
                end
            end
        end
    end

    assign dr_valid = valid_q;
    assign dr_word  = word_q;
    assign fill     = fill_q;
endmodule

// File: rtl/rng_errflags.sv
// Seed and clock error flags: "now" bits follow the faults, event bits are
// sticky until software writes 0 to them. Assumes fault inputs are synchronous.
module rng_errflags (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_fault,
    input  logic clk_fault,
    input  logic enable,
    input  logic ced_off,
    input  logic cond_active,
    input  logic clr_seed,
    input  logic clr_clk,
    output logic seed_now,
    output logic seed_evt,
    output logic clk_now,
    output logic clk_evt
);
    // Current-state flags, released automatically when the fault goes away.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_now <= 1'b0;
            clk_now  <= 1'b0;
        end else begin
            seed_now <= seed_fault & enable & ~cond_active;
            clk_now  <= clk_fault & ~ced_off;
        end
    end

    // Sticky event flags; a new fault wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_evt <= 1'b0;
            clk_evt  <= 1'b0;
        end else begin
            if (seed_fault & enable)  seed_evt <= 1'b1;
            else if (clr_seed)        seed_evt <= 1'b0;
            if (clk_fault & ~ced_off) clk_evt  <= 1'b1;
            else if (clr_clk)         clk_evt  <= 1'b0;
        end
    end
endmodule

// File: rtl/rng_periph.sv
// Top level of the random word generator: address decode, read multiplex
// and the run condition that ties source, output stage and error flags.
// Assumes one-cycle bus strobes; read data is valid in the strobe cycle.
module rng_periph
    import rng_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int COND_CYCLES = 16,
    parameter int PIPE_WORDS  = 12,
    parameter int TICKS_WORD  = 4,
    parameter int DIV_W       = 4,
    parameter int NSRC_W      = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              seed_fault_in,
    input  logic              clk_fault_in
);
    localparam int FILL_W = $clog2(PIPE_WORDS + 1);

    logic sel_ctrl, sel_stat, sel_data, sel_nsrc, sel_htst;
    logic ctrl_wr, stat_wr, dr_rd;
    logic enable, cond_active, cfg_locked, cfg_valid, run;
    rng_cfg_t cfg;
    logic [REG_W-1:0]  ctrl_rdata, htst_q, src_word, dr_word, stat_rdata;
    logic [NSRC_W-1:0] nsrc_q;
    logic              word_stb, dr_valid, drdy, pop;
    logic [FILL_W-1:0] fill;
    logic              seed_now, seed_evt, clk_now, clk_evt;

    // Register selects from the byte address.
    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
    assign sel_nsrc = (bus_addr == ADDR_W'(OFS_NSRC));
    assign sel_htst = (bus_addr == ADDR_W'(OFS_HTST));
    assign ctrl_wr  = bus_wr & sel_ctrl;
    assign stat_wr  = bus_wr & sel_stat;
    assign dr_rd    = bus_rd & sel_data;

    rng_ctrl #(
        .COND_CYCLES(COND_CYCLES),
        .NSRC_W     (NSRC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .nsrc_wr    (bus_wr & sel_nsrc),
        .htst_wr    (bus_wr & sel_htst),
        .wdata      (bus_wdata),
        .enable     (enable),
        .cfg        (cfg),
        .cond_active(cond_active),
        .cfg_locked (cfg_locked),
        .ctrl_rdata (ctrl_rdata),
        .nsrc_q     (nsrc_q),
        .htst_q     (htst_q)
    );

    assign cfg_valid = (|cfg.src_a) | (|cfg.src_b) | (|cfg.src_c);
    assign run       = enable & cfg_valid & ~cond_active & ~seed_now;

    rng_source #(
        .DIV_W         (DIV_W),
        .TICKS_PER_WORD(TICKS_WORD)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_exp (cfg.div_exp[DIV_W-1:0]),
        .word_stb(word_stb),
        .word    (src_word)
    );

    rng_outbuf #(
        .PIPE_WORDS(PIPE_WORDS)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cond_active | seed_now),
        .word_stb(word_stb),
        .word    (src_word),
        .pop     (pop),
        .dr_valid(dr_valid),
        .dr_word (dr_word),
        .fill    (fill)
    );

    rng_errflags u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_fault (seed_fault_in),
        .clk_fault  (clk_fault_in),
        .enable     (enable),
        .ced_off    (cfg.ced_off),
        .cond_active(cond_active),
        .clr_seed   (stat_wr & ~bus_wdata[SB_SEEDEVT]),
        .clr_clk    (stat_wr & ~bus_wdata[SB_CLKEVT]),
        .seed_now   (seed_now),
        .seed_evt   (seed_evt),
        .clk_now    (clk_now),
        .clk_evt    (clk_evt)
    );

    assign drdy = dr_valid & ~seed_now;
    assign pop  = dr_rd & drdy;

    // Status word assembly.
    always_comb begin
        stat_rdata             = '0;
        stat_rdata[SB_READY]   = drdy;
        stat_rdata[SB_CLKNOW]  = clk_now;
        stat_rdata[SB_SEEDNOW] = seed_now;
        stat_rdata[SB_CLKEVT]  = clk_evt;
        stat_rdata[SB_SEEDEVT] = seed_evt;
    end

    // Read data multiplexer; data reads give 0 unless a word is ready.
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) bus_rdata = ctrl_rdata;
        if (sel_stat) bus_rdata = stat_rdata;
        if (sel_data) bus_rdata = drdy ? dr_word : '0;
        if (sel_nsrc) bus_rdata = REG_W'(nsrc_q);
        if (sel_htst) bus_rdata = htst_q;
    end
endmodule

// File: rtl/rng_periph_chk.sv
// Assertion checker for rng_periph, attached by bind. Assumes the bus and
// fault inputs change only between rising edges.
module rng_periph_chk
    import rng_pkg::*;
#(
    parameter int PIPE_WORDS = 12,
    parameter int FILL_W     = $clog2(PIPE_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              stat_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              dr_rd,
    input logic              seed_fault_in,
    input logic              enable,
    input logic              cond_active,
    input logic              cfg_locked,
    input logic              cfg_valid,
    input rng_cfg_t          cfg,
    input logic              seed_now,
    input logic              seed_evt,
    input logic              clk_evt,
    input logic              drdy,
    input logic [FILL_W-1:0] fill
);
    // R3
    crst_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !cfg_locked && bus_wdata[CB_CRST] |=> cond_active);

    // R4
    drdy_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> (fill == FILL_W'(PIPE_WORDS)));

    // R5
    data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dr_rd && !drdy |-> (bus_rdata == '0));

    // R6
    nosrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid && !drdy |=> !drdy);

    // R7
    seed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_fault_in && enable && !cond_active |=> seed_now && seed_evt);

    // R8
    seed_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_fault_in |=> !seed_now);

    // R8
    seed_evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_evt && !(stat_wr && !bus_wdata[SB_SEEDEVT]) |=> seed_evt);

    // R9
    clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.ced_off && !clk_evt |=> !clk_evt);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked && $stable(cfg));
endmodule

bind rng_periph rng_periph_chk #(.PIPE_WORDS(PIPE_WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .stat_wr      (stat_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .dr_rd        (dr_rd),
    .seed_fault_in(seed_fault_in),
    .enable       (enable),
    .cond_active  (cond_active),
    .cfg_locked   (cfg_locked),
    .cfg_valid    (cfg_valid),
    .cfg          (cfg),
    .seed_now     (seed_now),
    .seed_evt     (seed_evt),
    .clk_evt      (clk_evt),
    .drdy         (drdy),
    .fill         (fill)
);

// File: tb/rng_periph_tb.sv
`timescale 1ns/1ps
// Directed bench for rng_periph: one task per scenario, each self-checking.
module rng_periph_tb;
    localparam logic [4:0]  A_CR = 5'h00, A_SR = 5'h04, A_DR = 5'h08,
                            A_NS = 5'h0C, A_HT = 5'h10;
    localparam logic [31:0] EN   = 32'h0000_0004;
    localparam logic [31:0] CEDO = 32'h0000_0020;
    localparam logic [31:0] CRST = 32'h4000_0000;
    localparam logic [31:0] LOCK = 32'h8000_0000;
    localparam logic [31:0] DIV1 = 32'h0001_0000;
    localparam logic [31:0] SRC  = 32'h0050_6300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        seed_fault_in = 1'b0, clk_fault_in = 1'b0;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    rng_periph u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seed_fault_in(seed_fault_in), .clk_fault_in(clk_fault_in)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CR, v); check("R1 ctrl", v, 0);
        rd(A_SR, v); check("R1 status", v, 0);
        rd(A_DR, v); check("R1 data", v, 0);
        rd(A_NS, v); check("R1 noise", v, 0);
        rd(A_HT, v); check("R1 health", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_NS, 32'hFFFF_FFFF); rd(A_NS, v); check("R11 noise width", v, 32'h0003_FFFF);
        wr(A_HT, 32'h5A3C_96E1); rd(A_HT, v); check("R11 health", v, 32'h5A3C_96E1);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        wr(A_CR, SRC | CRST | EN);
        rd(A_CR, v); check("R3 set reads 1", v, SRC | CRST | EN);
        wr(A_CR, EN);
        idle(15);
        rd(A_CR, v); check("R3 held at edge 15", v & CRST, CRST);
        rd(A_CR, v); check("R3 done at edge 16", v, SRC | EN);
        wr(A_CR, EN | DIV1 | 32'h0000_0F00);
        rd(A_CR, v); check("R2 no capture without restart", v, SRC | EN);
    endtask

    task automatic t_fill();
        logic [31:0] v, a, b;
        wr(A_CR, SRC | CRST | EN); wr(A_CR, EN);
        idle(60); rd(A_SR, v); check("R4 not ready before 12 words", v & 1, 0);
        idle(9);  rd(A_SR, v); check("R4 ready after 12 words", v & 1, 1);
        rd(A_DR, a); check("R5 word nonzero", a != 0, 1);
        idle(20);
        rd(A_DR, b); check("R5 second word nonzero", b != 0, 1);
        check("R5 words differ", a != b, 1);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        wr(A_CR, SRC | DIV1 | CRST | EN); wr(A_CR, EN);
        idle(105); rd(A_SR, v); check("R4 divided not ready", v & 1, 0);
        idle(14);  rd(A_SR, v); check("R4 divided ready", v & 1, 1);
    endtask

    task automatic t_seed();
        logic [31:0] v;
        seed_fault_in = 1'b1; idle(1);
        rd(A_SR, v); check("R7 seed flags", v, 32'h44);
        rd(A_DR, v); check("R7 data zero", v, 0);
        seed_fault_in = 1'b0; idle(1);
        rd(A_SR, v); check("R8 auto recover", v, 32'h40);
        idle(20); rd(A_SR, v); check("R8 flush pending", v, 32'h40);
        idle(120); rd(A_SR, v); check("R8 ready after flush", v, 32'h41);
        wr(A_SR, 32'h40); rd(A_SR, v); check("R8 write 1 keeps", v, 32'h41);
        wr(A_SR, 0);      rd(A_SR, v); check("R8 write 0 clears", v, 32'h01);
    endtask

    task automatic t_clock();
        logic [31:0] v;
        clk_fault_in = 1'b1; idle(1);
        rd(A_SR, v); check("R9 clock flags", v, 32'h23);
        clk_fault_in = 1'b0; idle(1);
        rd(A_SR, v); check("R9 now follows", v, 32'h21);
        wr(A_SR, 0); rd(A_SR, v); check("R9 event cleared", v, 32'h01);
        wr(A_CR, SRC | CEDO | CRST | EN); wr(A_CR, EN);
        clk_fault_in = 1'b1; idle(3);
        rd(A_SR, v); check("R9 detect off", v & 32'h22, 0);
        clk_fault_in = 1'b0;
    endtask

    task automatic t_nosrc();
        logic [31:0] v;
        wr(A_CR, CRST | EN); wr(A_CR, EN);
        idle(150);
        rd(A_SR, v); check("R6 never ready", v & 1, 0);
        rd(A_DR, v); check("R6 data zero", v, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(A_CR, SRC | CRST | EN); wr(A_CR, EN | LOCK);
        idle(20);
        rd(A_CR, v); check("R10 locked", v, SRC | EN | LOCK);
        wr(A_CR, CRST | DIV1 | EN);
        rd(A_CR, v); check("R10 cfg frozen", v, SRC | EN | LOCK);
        wr(A_NS, 32'h0000_1234);
        rd(A_NS, v); check("R10 noise frozen", v, 32'h0003_FFFF);
        wr(A_CR, 0);
        rd(A_CR, v); check("R10 enable writable, lock kept", v, SRC | LOCK);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_capture();
        t_fill();
        t_divider();
        t_seed();
        t_clock();
        t_nosrc();
        t_lock();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule